// File: doc/BRIEF.md
# Banked Event Interrupt Aggregator

This block gathers one-cycle event pulses from up to 96 on-chip sources and turns them into three level-sensitive interrupt requests. Each pulse carries a 7-bit code: the upper two bits pick one of three 32-bit pending words, and the lower five bits pick a bit in that word. A pending bit stays set until software clears it. The same pending bits feed three separate mask sets, one per request line. Line 0 has the highest priority, line 1 the middle and line 2 the lowest. A line is high while any pending bit under its mask is set.

Software uses a small word-addressed register port. It reads the pending words and writes ones to clear them, and it reads and writes the mask words. One cycle after reset is released, the block posts a fixed start-up event by itself. A request line is recomputed on every set, clear or mask change. It drops only when no masked pending bit is left in any bank.

Top module: `evt_irq_agg`

## Requirements
- R1: In the first clock cycle after reset is released, the block posts the event whose code is the parameter BOOT_CODE (default 0, which is bank 0 bit 0). That pending bit reads back as 1 afterwards.
- R2: When `evt_valid_i` is high at a clock edge, the code is decoded as follows: bits 6:5 give the bank and bits 4:0 give the bit. Exactly that pending bit is set, and it is readable in the next cycle.
- R3: Register map by word address. Pending bank b is at address b. The mask for line 0 (bank b) is at 4+b, for line 1 at 8+b, and for line 2 at 12+b. Each mask word reads back the last value written to it.
- R4: `irq_o[L]` in cycle n+1 equals the OR over all banks of (pending AND mask of line L) in cycle n. Bit 0 is the highest-priority line.
- R5: A write to a pending address clears each bit written as 1 and leaves bits written as 0 unchanged. Pending bits change by no other means apart from events.
- R6: After a clear, a line stays high while a masked pending bit remains in any bank. It falls only when none is left.
- R7: If an event and a clear hit the same pending bit in the same cycle, the bit ends up set.
- R8: Writing a mask bit that covers an already-pending bit raises that line one cycle after the write takes effect.
- R9: While reset is held, all pending and mask words read 0 and all request lines are low.
- R10: An event whose bank field is 3 changes no pending bit.
- R11: Reads from unmapped addresses (3, 7, 11, 15) return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid_i | input | 1 | Event pulse strobe |
| evt_code_i | input | 7 | Event code: bank in bits 6:5, bit in bits 4:0 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Write data (ones clear pending bits, full value for masks) |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| irq_o | output | 3 | Registered interrupt request lines, bit 0 highest priority |

## Verification
Two functions can fall in the same cycle: an incoming event pulse setting a bit, and a software write-one-to-clear of the same pending word. The bench drives the event code and a pending write of all ones in the same cycle. It expects the targeted bit to survive while nothing else is set. It then confirms the lowest-priority line rises from that surviving bit. A bound property also checks that every valid event leaves its bit set on the following cycle, whatever write lands beside it.

// File: rtl/evt_irq_pkg.sv
`timescale 1ns/1ps
package evt_irq_pkg;

   // Register group index carried in the upper address bits.
   localparam int unsigned PEND_GRP = 0;

   // Mask group for a given request line sits right after the pending group.
   function automatic int unsigned mask_grp(input int unsigned lvl);
      return lvl + 1;
   endfunction

endpackage

// File: rtl/evt_decode.sv
`timescale 1ns/1ps
module evt_decode #(
   parameter int unsigned N_BANKS = 3,
   parameter int unsigned BANK_W  = 32,
   localparam int unsigned IDX_W  = $clog2(BANK_W),
   localparam int unsigned SEL_W  = $clog2(N_BANKS),
   localparam int unsigned CODE_W = SEL_W + IDX_W
)(
   input  logic                            valid_i,
   input  logic [CODE_W-1:0]               code_i,
   output logic [N_BANKS-1:0][BANK_W-1:0]  set_o
);

   logic [SEL_W-1:0] sel;
   logic [IDX_W-1:0] idx;
   logic [BANK_W-1:0] onehot;

   assign sel    = code_i[CODE_W-1:IDX_W];
   assign idx    = code_i[IDX_W-1:0];
   assign onehot = BANK_W'(1) << idx;

   // Bank selectors above N_BANKS-1 match no lane and are dropped.
   for (genvar b = 0; b < int'(N_BANKS); b++) begin : g_lane
      assign set_o[b] = (valid_i && (sel == SEL_W'(b))) ? onehot : '0;
   end

endmodule

// File: rtl/evt_pend_bank.sv
`timescale 1ns/1ps
module evt_pend_bank #(
   parameter int unsigned BANK_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] set_i,
   input  logic [BANK_W-1:0] clr_i,
   output logic [BANK_W-1:0] pend_o
);

   logic [BANK_W-1:0] pend_q;

   // Clear first, then set: a simultaneous event keeps its bit.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_i) | set_i;
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/evt_lvl_mask.sv
`timescale 1ns/1ps
module evt_lvl_mask #(
   parameter int unsigned N_BANKS = 3,
   parameter int unsigned BANK_W  = 32,
   parameter bit          REG_OUT = 1'b1
)(
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [N_BANKS-1:0]              wr_i,
   input  logic [BANK_W-1:0]               wdata_i,
   input  logic [N_BANKS-1:0][BANK_W-1:0]  pend_i,
   output logic [N_BANKS-1:0][BANK_W-1:0]  mask_o,
   output logic                            irq_o
);

   logic [N_BANKS-1:0][BANK_W-1:0] mask_q;
   logic [N_BANKS-1:0]             bank_hit;
   logic                           any_hit;

   for (genvar b = 0; b < int'(N_BANKS); b++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     mask_q[b] <= '0;
         else if (wr_i[b]) mask_q[b] <= wdata_i;
      end
      assign bank_hit[b] = |(pend_i[b] & mask_q[b]);
   end

   assign any_hit = |bank_hit;
   assign mask_o  = mask_q;

   if (REG_OUT) begin : g_reg_out
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= any_hit;
      end
      assign irq_o = irq_q;
   end else begin : g_comb_out
      assign irq_o = any_hit;
   end

endmodule

// File: rtl/evt_reg_bus.sv
`timescale 1ns/1ps
module evt_reg_bus
   import evt_irq_pkg::*;
#(
   parameter int unsigned N_BANKS = 3,
   parameter int unsigned N_LVL   = 3,
   parameter int unsigned BANK_W  = 32,
   localparam int unsigned SEL_W  = $clog2(N_BANKS),
   localparam int unsigned GRP_W  = $clog2(N_LVL + 1),
   localparam int unsigned ADDR_W = SEL_W + GRP_W
)(
   input  logic                                       wr_i,
   input  logic [ADDR_W-1:0]                          addr_i,
   input  logic [BANK_W-1:0]                          wdata_i,
   input  logic [N_BANKS-1:0][BANK_W-1:0]             pend_i,
   input  logic [N_LVL-1:0][N_BANKS-1:0][BANK_W-1:0]  mask_i,
   output logic [N_BANKS-1:0][BANK_W-1:0]             clr_o,
   output logic [N_LVL-1:0][N_BANKS-1:0]              mwr_o,
   output logic [BANK_W-1:0]                          rdata_o
);

   logic [GRP_W-1:0] grp;
   logic [SEL_W-1:0] bnk;

   assign grp = addr_i[ADDR_W-1:SEL_W];
   assign bnk = addr_i[SEL_W-1:0];

   for (genvar b = 0; b < int'(N_BANKS); b++) begin : g_clr
      assign clr_o[b] = (wr_i && grp == GRP_W'(PEND_GRP) && bnk == SEL_W'(b))
                        ? wdata_i : '0;
   end

   for (genvar l = 0; l < int'(N_LVL); l++) begin : g_mwr_l
      for (genvar b = 0; b < int'(N_BANKS); b++) begin : g_mwr_b
         assign mwr_o[l][b] = wr_i && (grp == GRP_W'(mask_grp(l))) && (bnk == SEL_W'(b));
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int b = 0; b < int'(N_BANKS); b++) begin
         if (bnk == SEL_W'(b)) begin
            if (grp == GRP_W'(PEND_GRP)) rdata_o = pend_i[b];
            for (int l = 0; l < int'(N_LVL); l++) begin
               if (grp == GRP_W'(mask_grp(l))) rdata_o = mask_i[l][b];
            end
         end
      end
   end

endmodule

// File: rtl/evt_irq_agg.sv
`timescale 1ns/1ps
module evt_irq_agg #(
   parameter int unsigned N_BANKS   = 3,
   parameter int unsigned BANK_W    = 32,
   parameter int unsigned N_LVL     = 3,
   parameter int unsigned BOOT_CODE = 0,
   parameter bit          REG_OUT   = 1'b1,
   localparam int unsigned IDX_W    = $clog2(BANK_W),
   localparam int unsigned SEL_W    = $clog2(N_BANKS),
   localparam int unsigned CODE_W   = SEL_W + IDX_W,
   localparam int unsigned GRP_W    = $clog2(N_LVL + 1),
   localparam int unsigned ADDR_W   = SEL_W + GRP_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid_i,
   input  logic [CODE_W-1:0] evt_code_i,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [BANK_W-1:0] reg_wdata_i,
   output logic [BANK_W-1:0] reg_rdata_o,
   output logic [N_LVL-1:0]  irq_o
);

   // Elaboration-time parameter checks
   if (N_BANKS < 2) begin : g_bad_banks
      $error("N_BANKS must be at least 2");
   end
   if (BANK_W != (1 << IDX_W)) begin : g_bad_width
      $error("BANK_W must be a power of two");
   end
   if (N_LVL < 1) begin : g_bad_lvl
      $error("N_LVL must be at least 1");
   end
   if ((BOOT_CODE >> IDX_W) >= N_BANKS) begin : g_bad_boot
      $error("BOOT_CODE selects a bank that does not exist");
   end

   logic                                       boot_q;
   logic [N_BANKS-1:0][BANK_W-1:0]             set_ext;
   logic [N_BANKS-1:0][BANK_W-1:0]             set_boot;
   logic [N_BANKS-1:0][BANK_W-1:0]             set_all;
   logic [N_BANKS-1:0][BANK_W-1:0]             clr_w;
   logic [N_BANKS-1:0][BANK_W-1:0]             pend_w;
   logic [N_LVL-1:0][N_BANKS-1:0][BANK_W-1:0]  mask_w;
   logic [N_LVL-1:0][N_BANKS-1:0]              mwr_w;

   // One-shot start-up event in the first cycle out of reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) boot_q <= 1'b1;
      else        boot_q <= 1'b0;
   end

   evt_decode #(.N_BANKS(N_BANKS), .BANK_W(BANK_W)) u_dec_ext (
      .valid_i (evt_valid_i),
      .code_i  (evt_code_i),
      .set_o   (set_ext)
   );

   evt_decode #(.N_BANKS(N_BANKS), .BANK_W(BANK_W)) u_dec_boot (
      .valid_i (boot_q),
      .code_i  (CODE_W'(BOOT_CODE)),
      .set_o   (set_boot)
   );

   assign set_all = set_ext | set_boot;

   for (genvar b = 0; b < int'(N_BANKS); b++) begin : g_bank
      evt_pend_bank #(.BANK_W(BANK_W)) u_pend (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (set_all[b]),
         .clr_i  (clr_w[b]),
         .pend_o (pend_w[b])
      );
   end

   for (genvar l = 0; l < int'(N_LVL); l++) begin : g_lvl
      evt_lvl_mask #(.N_BANKS(N_BANKS), .BANK_W(BANK_W), .REG_OUT(REG_OUT)) u_mask (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_i    (mwr_w[l]),
         .wdata_i (reg_wdata_i),
         .pend_i  (pend_w),
         .mask_o  (mask_w[l]),
         .irq_o   (irq_o[l])
      );
   end

   evt_reg_bus #(.N_BANKS(N_BANKS), .N_LVL(N_LVL), .BANK_W(BANK_W)) u_bus (
      .wr_i    (reg_wr_i),
      .addr_i  (reg_addr_i),
      .wdata_i (reg_wdata_i),
      .pend_i  (pend_w),
      .mask_i  (mask_w),
      .clr_o   (clr_w),
      .mwr_o   (mwr_w),
      .rdata_o (reg_rdata_o)
   );

endmodule

// File: rtl/evt_irq_agg_chk.sv
`timescale 1ns/1ps
module evt_irq_agg_chk #(
   parameter int unsigned N_BANKS   = 3,
   parameter int unsigned BANK_W    = 32,
   parameter int unsigned N_LVL     = 3,
   parameter int unsigned BOOT_CODE = 0,
   parameter bit          REG_OUT   = 1'b1,
   localparam int unsigned IDX_W    = $clog2(BANK_W),
   localparam int unsigned SEL_W    = $clog2(N_BANKS),
   localparam int unsigned CODE_W   = SEL_W + IDX_W,
   localparam int unsigned GRP_W    = $clog2(N_LVL + 1),
   localparam int unsigned ADDR_W   = SEL_W + GRP_W
)(
   input logic                                       clk,
   input logic                                       rst_n,
   input logic                                       evt_valid,
   input logic [CODE_W-1:0]                          evt_code,
   input logic                                       reg_wr,
   input logic [ADDR_W-1:0]                          reg_addr,
   input logic [N_BANKS-1:0][BANK_W-1:0]             pend,
   input logic [N_LVL-1:0][N_BANKS-1:0][BANK_W-1:0]  mask,
   input logic [N_LVL-1:0]                           irq
);

   localparam int unsigned BOOT_BANK = BOOT_CODE >> IDX_W;
   localparam int unsigned BOOT_BIT  = BOOT_CODE % BANK_W;

   logic first_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) first_q <= 1'b1;
      else        first_q <= 1'b0;
   end

   logic [SEL_W-1:0] evt_sel;
   logic [IDX_W-1:0] evt_idx;
   assign evt_sel = evt_code[CODE_W-1:IDX_W];
   assign evt_idx = evt_code[IDX_W-1:0];

   // R1: start-up event lands in the first cycle after reset
   a_r1_boot_posted: assert property (@(posedge clk) disable iff (!rst_n)
      first_q |=> pend[BOOT_BANK][BOOT_BIT]);

   for (genvar b = 0; b < int'(N_BANKS); b++) begin : g_bank_chk
      // R5: without a clear write to this bank no pending bit falls
      a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         !(reg_wr && reg_addr == ADDR_W'(b))
         |=> ((pend[b] & $past(pend[b])) == $past(pend[b])));

      // R2 / R7: a valid event always leaves its bit set, clear or not
      a_r7_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_valid && evt_sel == SEL_W'(b)) |=> pend[b][$past(evt_idx)]);
   end

   // R10: bank field outside range leaves all pending words untouched
   a_r10_bad_bank_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && int'(evt_sel) >= int'(N_BANKS) && !reg_wr && !first_q)
      |=> $stable(pend));

   // R4: each line follows its masked pending state one cycle later
   logic [N_LVL-1:0] hit;
   always_comb begin
      hit = '0;
      for (int l = 0; l < int'(N_LVL); l++) begin
         for (int b = 0; b < int'(N_BANKS); b++) begin
            if ((pend[b] & mask[l][b]) != '0) hit[l] = 1'b1;
         end
      end
   end

   if (REG_OUT) begin : g_reg_chk
      a_r4_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq == $past(hit)));
   end else begin : g_comb_chk
      a_r4_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
         irq == hit);
   end

endmodule

bind evt_irq_agg evt_irq_agg_chk #(
   .N_BANKS(N_BANKS), .BANK_W(BANK_W), .N_LVL(N_LVL),
   .BOOT_CODE(BOOT_CODE), .REG_OUT(REG_OUT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_valid (evt_valid_i),
   .evt_code  (evt_code_i),
   .reg_wr    (reg_wr_i),
   .reg_addr  (reg_addr_i),
   .pend      (pend_w),
   .mask      (mask_w),
   .irq       (irq_o)
);

// File: tb/evt_irq_agg_tb.sv
`timescale 1ns/1ps
module evt_irq_agg_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_valid = 1'b0;
   logic [6:0]  evt_code = '0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [2:0]  irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   evt_irq_agg dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_valid_i (evt_valid),
      .evt_code_i  (evt_code),
      .reg_wr_i    (reg_wr),
      .reg_addr_i  (reg_addr),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .irq_o       (irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic post(input logic [6:0] c);
      evt_code = c; evt_valid = 1'b1;
      @(negedge clk);
      evt_valid = 1'b0; evt_code = '0;
   endtask

   task automatic t_reset_boot();
      logic [31:0] d;
      for (int a = 0; a < 16; a++) begin
         rd(4'(a), d);
         check("R9 reset word", d, 32'h0);
      end
      check("R9 reset irq", {29'h0, irq}, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      rd(4'd0, d); check("R1 boot bit bank0", d, 32'h0000_0001);
      rd(4'd1, d); check("R1 bank1 untouched", d, 32'h0);
      check("R1 irq masked", {29'h0, irq}, 32'h0);
   endtask

   task automatic t_decode();
      logic [31:0] d;
      wr(4'd0, 32'h0000_0001);
      rd(4'd0, d); check("R5 boot cleared", d, 32'h0);
      post(7'h27);
      rd(4'd1, d); check("R2 bank1 bit7", d, 32'h0000_0080);
      rd(4'd0, d); check("R2 bank0 clean", d, 32'h0);
      rd(4'd2, d); check("R2 bank2 clean", d, 32'h0);
      @(negedge clk);
      check("R4 unmasked no irq", {29'h0, irq}, 32'h0);
   endtask

   task automatic t_mask_rw();
      logic [31:0] d;
      wr(4'd4,  32'hA5A5_0001);
      wr(4'd9,  32'h1234_5678);
      wr(4'd14, 32'hFFFF_0000);
      rd(4'd4,  d); check("R3 mask line0 bank0", d, 32'hA5A5_0001);
      rd(4'd9,  d); check("R3 mask line1 bank1", d, 32'h1234_5678);
      rd(4'd14, d); check("R3 mask line2 bank2", d, 32'hFFFF_0000);
      rd(4'd5,  d); check("R3 mask line0 bank1", d, 32'h0);
      wr(4'd4, 32'h0); wr(4'd9, 32'h0); wr(4'd14, 32'h0);
      @(negedge clk);
      check("R4 masks cleared irq", {29'h0, irq}, 32'h0);
   endtask

   task automatic t_unmask();
      wr(4'd9, 32'h0000_0080);
      check("R8 irq not yet", {29'h0, irq}, 32'h0);
      @(negedge clk);
      check("R8 line1 raised", {29'h0, irq}, 32'h2);
   endtask

   task automatic t_w1c();
      logic [31:0] d;
      post(7'h21);
      rd(4'd1, d); check("R2 bank1 bit1 added", d, 32'h0000_0082);
      wr(4'd1, 32'h0000_0002);
      rd(4'd1, d); check("R5 zero bits kept", d, 32'h0000_0080);
      @(negedge clk);
      check("R5 line1 still up", {29'h0, irq}, 32'h2);
   endtask

   task automatic t_multi_bank();
      logic [31:0] d;
      wr(4'd4, 32'h0000_0008);
      wr(4'd6, 32'h8000_0000);
      post(7'h03);
      post(7'h5F);
      rd(4'd2, d); check("R2 bank2 bit31", d, 32'h8000_0000);
      @(negedge clk);
      check("R4 line0 and line1", {29'h0, irq}, 32'h3);
      wr(4'd0, 32'h0000_0008);
      @(negedge clk);
      check("R6 line0 held by bank2", {29'h0, irq}, 32'h3);
      wr(4'd2, 32'h8000_0000);
      @(negedge clk);
      check("R6 line0 drops", {29'h0, irq}, 32'h2);
      wr(4'd1, 32'h0000_0080);
      @(negedge clk);
      check("R6 all lines low", {29'h0, irq}, 32'h0);
   endtask

   task automatic t_collision();
      logic [31:0] d;
      wr(4'd12, 32'h0000_0010);
      evt_code = 7'h04; evt_valid = 1'b1;
      reg_addr = 4'd0; reg_wdata = 32'hFFFF_FFFF; reg_wr = 1'b1;
      @(negedge clk);
      evt_valid = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
      rd(4'd0, d); check("R7 event wins over clear", d, 32'h0000_0010);
      @(negedge clk);
      check("R7 line2 raised", {29'h0, irq}, 32'h4);
      wr(4'd0, 32'h0000_0010);
      @(negedge clk);
      check("R6 line2 drops", {29'h0, irq}, 32'h0);
   endtask

   task automatic t_bad_bank();
      logic [31:0] d;
      post(7'h60);
      post(7'h7F);
      for (int a = 0; a < 3; a++) begin
         rd(4'(a), d);
         check("R10 bank3 code ignored", d, 32'h0);
      end
      @(negedge clk);
      check("R10 no irq", {29'h0, irq}, 32'h0);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      rd(4'd3,  d); check("R11 addr3", d, 32'h0);
      rd(4'd7,  d); check("R11 addr7", d, 32'h0);
      rd(4'd11, d); check("R11 addr11", d, 32'h0);
      rd(4'd15, d); check("R11 addr15", d, 32'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset_boot();
      t_decode();
      t_mask_rw();
      t_unmask();
      t_w1c();
      t_multi_bank();
      t_collision();
      t_bad_bank();
      t_unmapped();
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule